// File: doc/BRIEF.md
# Bubble-Through Handshake FIFO

This block is a first-in first-out store made from a chain of storage positions instead of a RAM with read and write pointers. Each position holds one word plus a bit that says whether it is occupied. A word that enters at the head moves one position toward the tail on every clock, as long as the position ahead of it is empty. It stops behind the last occupied position, so the oldest word always sits at the tail and is shown on the outputs. The defaults are 64 positions of 4 bits.

The writer sees a ready flag that is high while the head position is empty. It raises a shift-in strobe to hand over a word. The reader sees a ready flag that is high while the tail position holds a word, and raises a shift-out strobe to take that word away. Each high phase of a strobe moves exactly one word, so a strobe can be held high. Both flags come straight from registers, so one instance can feed another directly: the upstream output-ready flag drives the downstream shift-in, and the downstream input-ready flag drives the upstream shift-out. The chained pair then acts as one FIFO of twice the depth. Side-by-side instances are widened by ANDing their ready flags. The three-state output is modelled as a data bus plus a separate drive-enable output.

Top module: `bubble_fifo`

## Requirements
- R1: A cycle with rst_n low empties every position. After that edge, din_ready is 1, dout_ready is 0 and dout is 0.
- R2: A word on din is captured at a rising clock edge only when shift_in is high, the write strobe is armed, and din_ready is high. din_ready is 0 in the cycle that follows a capture.
- R3: A strobe is armed from reset, and again after any cycle in which it was sampled low. Each high phase of shift_in captures at most one word, and each high phase of shift_out removes at most one word, however long the strobe is held.
- R4: A word written into an empty FIFO reaches the tail, with dout_ready going high, exactly DEPTH-1 clock edges after the edge that captured it.
- R5: While dout_ready is high and no word is removed, dout holds the tail word and does not change.
- R6: A removal happens at an edge where shift_out is high, the read strobe is armed and dout_ready is high. dout_ready is 0 in the following cycle. If the position behind the tail was occupied, the next word appears one cycle after that.
- R7: Words leave in the order in which they were captured, under any timing of the two strobes.
- R8: The FIFO holds DEPTH words. When it is full, din_ready stays 0, and a held shift_in has no effect until a word has been removed and a free position has reached the head.
- R9: dout_oe follows out_en in the same cycle. out_en has no effect on the stored words or on the flags.
- R10: Two instances chained in depth (upstream dout to downstream din, upstream dout_ready to downstream shift_in, downstream din_ready to upstream shift_out) accept 2*DEPTH words and deliver them in order.
- R11: A capture and a removal at the same edge both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset that empties the FIFO |
| shift_in | input | 1 | Write strobe; one word per high phase |
| din | input | WIDTH | Word to write |
| din_ready | output | 1 | High while the head position is free |
| shift_out | input | 1 | Read strobe; one word per high phase |
| dout_ready | output | 1 | High while the tail position holds a word |
| out_en | input | 1 | Output drive enable request |
| dout | output | WIDTH | Tail word |
| dout_oe | output | 1 | Drive enable for dout (high-impedance when low) |

## Verification
The two functions that can fall on the same edge are a capture at the head and a removal at the tail. The bench provokes this directly with a partly filled, settled FIFO: it raises both strobes at the same falling edge and checks, one cycle later, that both ready flags have dropped and that the drained sequence is complete and in order. The same overlap also occurs on its own in the chained pair, where the upstream removal and the downstream capture always happen at one edge. Any loss or duplication there shows up as a break in the 2*DEPTH-word sequence.

// File: rtl/bfifo_pkg.sv
// Package: shared defaults for the bubble-through FIFO.
// Assumes: nothing; holds only constants used by every module.
package bfifo_pkg;
    localparam int unsigned DEF_DEPTH = 64;
    localparam int unsigned DEF_WIDTH = 4;
endpackage

// File: rtl/bfifo_strobe.sv
// Module: turns a level strobe into one transfer per high phase.
// Assumes: strobe is synchronous to clk; ready is a registered flag.
// The strobe is armed out of reset, so a strobe already high at reset
// release counts as one pulse (needed when instances are chained).
module bfifo_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic ready,
    output logic fire
);
    logic armed_q;

    assign fire = strobe & armed_q & ready;

    // Arm on a low sample, disarm on the transfer it allows.
    always_ff @(posedge clk) begin
        if (!rst_n)       armed_q <= 1'b1;
        else if (fire)    armed_q <= 1'b0;
        else if (!strobe) armed_q <= 1'b1;
    end

    AST_ONE_PER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire); // R3
endmodule

// File: rtl/bfifo_cell.sv
// Module: one storage position with its occupancy bit.
// Assumes: fill is only raised while the position is empty; drain only
// while it is full (the chain guarantees both).
module bfifo_cell #(
    parameter int unsigned WIDTH = bfifo_pkg::DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill,
    input  logic             drain,
    input  logic [WIDTH-1:0] d_in,
    output logic             full,
    output logic [WIDTH-1:0] d_out
);
    logic             full_q;
    logic [WIDTH-1:0] data_q;

    assign full  = full_q;
    assign d_out = data_q;

    // Occupancy: set when a word arrives, cleared when it leaves.
    always_ff @(posedge clk) begin
        if (!rst_n) full_q <= 1'b0;
        else        full_q <= (full_q & ~drain) | fill;
    end

    // Data: loaded only on arrival, otherwise kept.
    always_ff @(posedge clk) begin
        if (!rst_n)    data_q <= '0;
        else if (fill) data_q <= d_in;
    end

    AST_NO_CLOBBER: assert property (@(posedge clk) disable iff (!rst_n)
        fill |-> !full_q); // R7
    AST_WORD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && !drain) |=> (full_q && $stable(data_q))); // R8
endmodule

// File: rtl/bfifo_chain.sv
// Module: the chain of DEPTH positions; a word steps forward whenever the
// position ahead is empty, so free slots travel back toward the head.
// Assumes: wr only while the head is empty, rd only while the tail is full.
module bfifo_chain #(
    parameter int unsigned DEPTH = bfifo_pkg::DEF_DEPTH,
    parameter int unsigned WIDTH = bfifo_pkg::DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd,
    output logic             head_full,
    output logic             tail_full,
    output logic [WIDTH-1:0] tail_data
);
    localparam int unsigned LAST = DEPTH - 1;

    logic [DEPTH-1:0] occ;
    logic [DEPTH-1:0] fill;
    logic [DEPTH-1:0] drain;
    logic [WIDTH-1:0] dat [DEPTH];

    genvar k;
    generate
        for (k = 0; k < DEPTH; k++) begin : g_pos
            // Arrival: external write at the head, else a step from behind.
            if (k == 0) begin : g_head
                assign fill[k] = wr;
            end else begin : g_body
                assign fill[k] = occ[k-1] & ~occ[k];
            end
            // Departure: external read at the tail, else a step forward.
            if (k == LAST) begin : g_tail
                assign drain[k] = rd;
            end else begin : g_mid
                assign drain[k] = occ[k] & ~occ[k+1];
            end

            if (k == 0) begin : g_cell0
                bfifo_cell #(.WIDTH(WIDTH)) i_cell (
                    .clk(clk), .rst_n(rst_n), .fill(fill[k]), .drain(drain[k]),
                    .d_in(wr_data), .full(occ[k]), .d_out(dat[k])
                );
            end else begin : g_celln
                bfifo_cell #(.WIDTH(WIDTH)) i_cell (
                    .clk(clk), .rst_n(rst_n), .fill(fill[k]), .drain(drain[k]),
                    .d_in(dat[k-1]), .full(occ[k]), .d_out(dat[k])
                );
            end
        end
    endgenerate

    assign head_full = occ[0];
    assign tail_full = occ[LAST];
    assign tail_data = dat[LAST];

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && !rd) |=> ($countones(occ) == $countones($past(occ)))); // R7
endmodule

// File: rtl/bubble_fifo.sv
// Module: top of the bubble-through FIFO with level handshakes.
// Assumes: all strobes synchronous to clk; flags are registered so that
// instances can be wired flag-to-strobe without combinational loops.
module bubble_fifo #(
    parameter int unsigned DEPTH = bfifo_pkg::DEF_DEPTH,
    parameter int unsigned WIDTH = bfifo_pkg::DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_in,
    input  logic [WIDTH-1:0] din,
    output logic             din_ready,
    input  logic             shift_out,
    output logic             dout_ready,
    input  logic             out_en,
    output logic [WIDTH-1:0] dout,
    output logic             dout_oe
);
    logic wr;
    logic rd;
    logic head_full;
    logic tail_full;

    bfifo_strobe i_wr_strobe (
        .clk(clk), .rst_n(rst_n), .strobe(shift_in), .ready(din_ready), .fire(wr)
    );

    bfifo_strobe i_rd_strobe (
        .clk(clk), .rst_n(rst_n), .strobe(shift_out), .ready(dout_ready), .fire(rd)
    );

    bfifo_chain #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_chain (
        .clk(clk), .rst_n(rst_n), .wr(wr), .wr_data(din), .rd(rd),
        .head_full(head_full), .tail_full(tail_full), .tail_data(dout)
    );

    assign din_ready  = ~head_full;
    assign dout_ready = tail_full;
    assign dout_oe    = out_en;

    AST_DIR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> !din_ready); // R2
    AST_DOR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_ready && !rd) |=> (dout_ready && $stable(dout))); // R5
    AST_DOR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> !dout_ready); // R6
endmodule

// File: tb/test_bubble_fifo.sv
module test_bubble_fifo;
    localparam int D = 64;
    localparam int W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic si = 1'b0, so = 1'b0, oe = 1'b1;
    logic [W-1:0] din = '0;
    logic dir, dor, doe;
    logic [W-1:0] dout;

    // chained pair
    logic a_si = 1'b0, b_so = 1'b0;
    logic [W-1:0] a_din = '0;
    logic a_dir, a_dor, a_doe, b_dir, b_dor, b_doe;
    logic [W-1:0] a_dout, b_dout;

    int tests = 0, fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bubble_fifo #(.DEPTH(D), .WIDTH(W)) i_bubble_fifo (
        .clk(clk), .rst_n(rst_n), .shift_in(si), .din(din), .din_ready(dir),
        .shift_out(so), .dout_ready(dor), .out_en(oe), .dout(dout), .dout_oe(doe)
    );
    bubble_fifo #(.DEPTH(D), .WIDTH(W)) i_chain_a (
        .clk(clk), .rst_n(rst_n), .shift_in(a_si), .din(a_din), .din_ready(a_dir),
        .shift_out(b_dir), .dout_ready(a_dor), .out_en(1'b1), .dout(a_dout), .dout_oe(a_doe)
    );
    bubble_fifo #(.DEPTH(D), .WIDTH(W)) i_chain_b (
        .clk(clk), .rst_n(rst_n), .shift_in(a_dor), .din(a_dout), .din_ready(b_dir),
        .shift_out(b_so), .dout_ready(b_dor), .out_en(1'b1), .dout(b_dout), .dout_oe(b_doe)
    );

    function automatic logic [W-1:0] f(input int i);
        return W'((i * 5 + 3) % 16);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [W-1:0] v);
        while (!dir) @(negedge clk);
        din = v; si = 1'b1;
        @(negedge clk);
        si = 1'b0;
    endtask

    task automatic pop(output logic [W-1:0] v);
        while (!dor) @(negedge clk);
        v = dout; so = 1'b1;
        @(negedge clk);
        so = 1'b0;
    endtask

    task automatic drain_expect(input int first, input int n, input string req);
        for (int j = 0; j < n; j++) begin
            logic [W-1:0] v;
            pop(v);
            check(v == f(first + j), req, "drained word", v, f(first + j));
        end
    endtask

    task automatic cpush(input logic [W-1:0] v);
        while (!a_dir) @(negedge clk);
        a_din = v; a_si = 1'b1;
        @(negedge clk);
        a_si = 1'b0;
    endtask

    task automatic cpop(output logic [W-1:0] v);
        while (!b_dor) @(negedge clk);
        v = b_dout; b_so = 1'b1;
        @(negedge clk);
        b_so = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; si = 1'b0; so = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v;
        int cnt;
        @(negedge clk);
        do_reset();
        // R1 reset state
        check(dir == 1'b1, "R1", "din_ready after reset", dir, 1);
        check(dor == 1'b0, "R1", "dout_ready after reset", dor, 0);
        check(dout == '0, "R1", "dout after reset", dout, 0);

        // R4 latency, R2 flag drop
        din = f(0); si = 1'b1;
        @(negedge clk);
        si = 1'b0;
        check(dir == 1'b0, "R2", "din_ready after capture", dir, 0);
        cnt = 0;
        while (!dor && cnt < 200) begin @(negedge clk); cnt++; end
        check(cnt == D - 1, "R4", "fall-through edges", cnt, D - 1);

        // R5 steady output
        repeat (5) @(negedge clk);
        check(dor && dout == f(0), "R5", "tail word held", dout, f(0));

        // R9 output enable
        oe = 1'b0; #1;
        check(doe == 1'b0, "R9", "dout_oe low", doe, 0);
        @(negedge clk);
        check(dor && dout == f(0) && dir, "R9", "contents with oe low", dout, f(0));
        oe = 1'b1; #1;
        check(doe == 1'b1, "R9", "dout_oe high", doe, 1);

        // R8 capacity
        for (int i = 1; i < D; i++) push(f(i));
        repeat (80) @(negedge clk);
        check(dir == 1'b0, "R8", "din_ready when full", dir, 0);
        din = 4'hF; si = 1'b1;
        repeat (10) @(negedge clk);
        check(dir == 1'b0 && dout == f(0), "R8", "held shift_in while full", dout, f(0));
        pop(v);
        check(v == f(0), "R8", "first word", v, f(0));
        check(dor == 1'b0, "R6", "dout_ready gap", dor, 0);
        @(negedge clk);
        check(dor == 1'b1 && dout == f(1), "R6", "next word after gap", dout, f(1));
        repeat (100) @(negedge clk);
        si = 1'b0;
        check(dir == 1'b0, "R8", "full again after late capture", dir, 0);
        drain_expect(1, D - 1, "R7");
        pop(v);
        check(v == 4'hF, "R3", "held word captured once", v, 15);
        repeat (80) @(negedge clk);
        check(dor == 1'b0, "R3", "no duplicate of held word", dor, 0);

        // R11 same-edge capture and removal
        do_reset();
        for (int i = 0; i < 10; i++) push(f(i));
        repeat (80) @(negedge clk);
        v = dout; din = f(10); si = 1'b1; so = 1'b1;
        @(negedge clk);
        si = 1'b0; so = 1'b0;
        check(v == f(0), "R11", "word removed", v, f(0));
        check(dir == 1'b0 && dor == 1'b0, "R11", "both flags dropped",
              {30'd0, dir, dor}, 0);
        drain_expect(1, 10, "R11");

        // R3 held shift_out removes one word
        do_reset();
        for (int i = 0; i < 3; i++) push(f(i));
        repeat (80) @(negedge clk);
        so = 1'b1;
        repeat (10) @(negedge clk);
        check(dor == 1'b1 && dout == f(1), "R3", "one removal per high phase", dout, f(1));
        so = 1'b0;
        @(negedge clk);
        drain_expect(1, 2, "R3");

        // R7 random strobe timing
        do_reset();
        fork
            for (int i = 0; i < 300; i++) begin
                repeat ($urandom % 4) @(negedge clk);
                push(f(i));
            end
            for (int j = 0; j < 300; j++) begin
                logic [W-1:0] r;
                repeat ($urandom % 5) @(negedge clk);
                pop(r);
                check(r == f(j), "R7", "random order", r, f(j));
            end
        join

        // R10 chained pair
        do_reset();
        for (int i = 0; i < 2 * D - 1; i++) cpush(f(i));
        repeat (1500) @(negedge clk);
        check(a_dir == 1'b1, "R10", "room for last word", a_dir, 1);
        cpush(f(2 * D - 1));
        repeat (300) @(negedge clk);
        check(a_dir == 1'b0, "R10", "full at 2*DEPTH", a_dir, 0);
        for (int j = 0; j < 2 * D; j++) begin
            logic [W-1:0] r;
            cpop(r);
            check(r == f(j), "R10", "chained order", r, f(j));
        end
        repeat (300) @(negedge clk);
        check(b_dor == 1'b0, "R10", "chain empty", b_dor, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule